// File: doc/BRIEF.md
# Exception Entry Bus Sequencer

This block produces the bus activity that an 8-bit CPU core with a 16-bit native mode performs when it takes an exception. The kinds are reset, NMI, IRQ, abort and software break. A single-cycle start strobe latches the exception kind, the emulation flag, the program bank, the PC, the status byte and the stack pointer. From the next cycle on, the block drives exactly one bus operation per clock: an operation code, a 24-bit address and the write data.

The sequence runs in four phases:
- Dummy program reads at the current program address.
- The machine state is saved on the stack, highest-order byte first.
- The two vector bytes are fetched from bank zero.
- A one-cycle done strobe is raised. It carries the new PC built from the vector, a cleared program bank and the final stack pointer.

In emulation mode the program bank is not saved. That removes one cycle and one stack byte, and the stack stays confined to page one.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle: busy_o is 0, done_o is 0, op_o is 0 (none) and wdata_o is 0.
- R2: Operation codes on op_o are 0 none, 1 internal (a discarded read), 2 write and 3 read. wdata_o is 0 in every cycle that is not a write.
- R3: In the first cycle after a start strobe, a hardware kind (kind_i: 0 reset, 1 NMI, 2 IRQ, 3 abort) issues two internal cycles at address {pbr_i, pc_i}. Break (kind_i = 4) issues one such cycle.
- R4: In native mode (emu_i = 0), four stack cycles follow in this order: program bank, PC high byte, PC low byte, status byte.
- R5: In emulation mode (emu_i = 1), the program bank cycle is omitted and only three stack cycles occur.
- R6: Each stack cycle uses address {8'h00, SP} and then decrements SP. In emulation mode, SP bits 15:8 are held at 8'h01 and the low byte wraps within that page.
- R7: A reset-kind entry issues its stack cycles as reads (code 3) and never writes.
- R8: The vector is read from bank 0, low byte at the base address and then high byte at base+1. The base addresses are listed below.

  | Kind | Native base | Emulation base |
  |------|-------------|----------------|
  | abort | 16'hFFE8 | 16'hFFF8 |
  | NMI | 16'hFFEA | 16'hFFFA |
  | IRQ | 16'hFFEE | 16'hFFFE |
  | break | 16'hFFE6 | 16'hFFFE |
  | reset | 16'hFFFC | 16'hFFFC |

- R9: The cycle after the high vector read raises done_o for exactly one cycle. In that cycle new_pc_o is {high byte, low byte}, new_pbr_o is 0 and sp_o holds the decremented stack pointer. The block is idle in the next cycle.
- R10: A start strobe that arrives while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin exception entry (sampled when idle) |
| kind_i | input | 3 | Exception kind |
| emu_i | input | 1 | Emulation mode flag |
| pbr_i | input | 8 | Current program bank |
| pc_i | input | 16 | Current program counter |
| p_i | input | 8 | Current status byte |
| sp_i | input | 16 | Current stack pointer |
| rdata_i | input | 8 | Read data for the current read cycle |
| op_o | output | 2 | Bus operation code |
| addr_o | output | 24 | Bus address |
| wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion strobe |
| new_pc_o | output | 16 | Vector target PC |
| new_pbr_o | output | 8 | Program bank after entry |
| sp_o | output | 16 | Running stack pointer |

## Verification
The bench builds the block with its default emulation stack page of 8'h01, the only value the architecture uses. It sweeps every exception kind in both modes over four register patterns. Those patterns include stack pointers that wrap below zero within page one and across the full native range. The read data comes from an address-derived memory model, so every vector table entry and the byte order of the new PC are checked arithmetically. A stray start strobe in mid-sequence brings the ignore rule within reach.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int BW = 8;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0, EXC_NMI = 3'd1, EXC_IRQ = 3'd2, EXC_ABORT = 3'd3, EXC_BREAK = 3'd4
  } exc_kind_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0, BUS_IO = 2'd1, BUS_WRITE = 2'd2, BUS_READ = 2'd3
  } bus_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_IO0, ST_IO1, ST_PBR, ST_PCH, ST_PCL, ST_PSW, ST_VLO, ST_VHI, ST_DONE
  } seq_state_e;

  function automatic logic [AW-1:0] vector_base(exc_kind_e kind, logic emu);
    logic [AW-1:0] v;
    case (kind)
      EXC_RESET: v = 16'hFFFC;
      EXC_NMI:   v = emu ? 16'hFFFA : 16'hFFEA;
      EXC_ABORT: v = emu ? 16'hFFF8 : 16'hFFE8;
      EXC_BREAK: v = emu ? 16'hFFFE : 16'hFFE6;
      default:   v = emu ? 16'hFFFE : 16'hFFEE;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  exc_kind_e  start_kind_i,
  input  logic       emu_q_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (start_kind_i == EXC_BREAK) ? ST_IO1 : ST_IO0;
      ST_IO0:  state_d = ST_IO1;
      ST_IO1:  state_d = emu_q_i ? ST_PCH : ST_PBR;
      ST_PBR:  state_d = ST_PCH;
      ST_PCH:  state_d = ST_PCL;
      ST_PCL:  state_d = ST_PSW;
      ST_PSW:  state_d = ST_VLO;
      ST_VLO:  state_d = ST_VHI;
      ST_VHI:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;
endmodule

// File: rtl/exc_stack_unit.sv
module exc_stack_unit
  import exc_pkg::*;
#(
  parameter logic [BW-1:0] EMU_PAGE = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] sp_i,
  input  logic          emu_i,
  input  logic          dec_i,
  input  logic          emu_q_i,
  output logic [AW-1:0] sp_o
);
  localparam int LW = AW - BW;
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sp_q <= '0;
    else if (load_i) sp_q <= emu_i ? {EMU_PAGE, sp_i[LW-1:0]} : sp_i;
    else if (dec_i) begin
      if (emu_q_i) sp_q <= {EMU_PAGE, sp_q[LW-1:0] - 1'b1};
      else         sp_q <= sp_q - 1'b1;
    end

  assign sp_o = sp_q;
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  exc_kind_e     kind_i,
  input  logic          emu_i,
  input  seq_state_e    state_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] vec_addr_o,
  output logic [AW-1:0] new_pc_o
);
  logic [AW-1:0] base;
  logic [DW-1:0] lo_q;
  logic [AW-1:0] pc_q;

  assign base       = vector_base(kind_i, emu_i);
  assign vec_addr_o = (state_i == ST_VHI) ? base + 1'b1 : base;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lo_q <= '0;
      pc_q <= '0;
    end else if (state_i == ST_VLO) lo_q <= rdata_i;
    else if (state_i == ST_VHI)     pc_q <= {rdata_i, lo_q};

  assign new_pc_o = pc_q;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter logic [7:0] EMU_STACK_PAGE = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [2:0]  kind_i,
  input  logic        emu_i,
  input  logic [7:0]  pbr_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  p_i,
  input  logic [15:0] sp_i,
  input  logic [7:0]  rdata_i,
  output logic [1:0]  op_o,
  output logic [23:0] addr_o,
  output logic [7:0]  wdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] new_pc_o,
  output logic [7:0]  new_pbr_o,
  output logic [15:0] sp_o
);
  seq_state_e    state;
  exc_kind_e     kind_q;
  logic          emu_q;
  logic [BW-1:0] pbr_q, p_q, pbr_out_q;
  logic [AW-1:0] pc_q, vec_addr, sp;
  logic          load, push;
  bus_op_e       op;

  assign load = (state == ST_IDLE) && start_i;
  assign push = (state == ST_PBR) || (state == ST_PCH) || (state == ST_PCL) || (state == ST_PSW);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      kind_q    <= EXC_RESET;
      emu_q     <= 1'b0;
      pbr_q     <= '0;
      pc_q      <= '0;
      p_q       <= '0;
      pbr_out_q <= '0;
    end else if (load) begin
      kind_q    <= exc_kind_e'(kind_i);
      emu_q     <= emu_i;
      pbr_q     <= pbr_i;
      pc_q      <= pc_i;
      p_q       <= p_i;
      pbr_out_q <= pbr_i;
    end else if (state == ST_VHI) begin
      pbr_out_q <= '0;
    end

  exc_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i,
    .start_kind_i (exc_kind_e'(kind_i)),
    .emu_q_i      (emu_q),
    .state_o      (state)
  );

  exc_stack_unit #(.EMU_PAGE(EMU_STACK_PAGE)) u_stack (
    .clk_i, .rst_ni,
    .load_i  (load),
    .sp_i,
    .emu_i,
    .dec_i   (push),
    .emu_q_i (emu_q),
    .sp_o    (sp)
  );

  exc_vector_unit u_vec (
    .clk_i, .rst_ni,
    .kind_i     (kind_q),
    .emu_i      (emu_q),
    .state_i    (state),
    .rdata_i,
    .vec_addr_o (vec_addr),
    .new_pc_o
  );

  always_comb begin
    op      = BUS_NONE;
    addr_o  = '0;
    wdata_o = '0;
    if (state == ST_IO0 || state == ST_IO1) begin
      op     = BUS_IO;
      addr_o = {pbr_q, pc_q};
    end else if (push) begin
      // reset entry performs stack cycles as reads
      op     = (kind_q == EXC_RESET) ? BUS_READ : BUS_WRITE;
      addr_o = {8'h00, sp};
      if (op == BUS_WRITE) begin
        unique case (state)
          ST_PBR:  wdata_o = pbr_q;
          ST_PCH:  wdata_o = pc_q[15:8];
          ST_PCL:  wdata_o = pc_q[7:0];
          default: wdata_o = p_q;
        endcase
      end
    end else if (state == ST_VLO || state == ST_VHI) begin
      op     = BUS_READ;
      addr_o = {8'h00, vec_addr};
    end
  end

  assign op_o      = op;
  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_DONE);
  assign new_pbr_o = pbr_out_q;
  assign sp_o      = sp;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [1:0]  op_o,
  input logic [23:0] addr_o,
  input logic [7:0]  wdata_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [7:0]  new_pbr_o,
  input logic [15:0] sp_o,
  input logic        emu_q,
  input logic [2:0]  kind_q
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (op_o == 2'd0 && wdata_o == 8'h00));

  assert_write_bank0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == 2'd2) |-> (addr_o[23:16] == 8'h00));

  assert_emu_page_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == 2'd2 && emu_q) |-> (addr_o[15:8] == 8'h01));

  assert_sp_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == 2'd2) |=> (sp_o[7:0] == $past(sp_o[7:0]) - 8'd1));

  assert_reset_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && kind_q == 3'd0) |-> (op_o != 2'd2));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_done_bank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (new_pbr_o == 8'h00));

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .op_o      (op_o),
  .addr_o    (addr_o),
  .wdata_o   (wdata_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .new_pbr_o (new_pbr_o),
  .sp_o      (sp_o),
  .emu_q     (emu_q),
  .kind_q    (kind_q)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic        emu_i = 1'b0;
  logic [7:0]  pbr_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  p_i = '0;
  logic [15:0] sp_i = '0;
  logic [7:0]  rdata_i;
  logic [1:0]  op_o;
  logic [23:0] addr_o;
  logic [7:0]  wdata_o;
  logic        busy_o, done_o;
  logic [15:0] new_pc_o;
  logic [7:0]  new_pbr_o;
  logic [15:0] sp_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] mem(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  assign rdata_i = mem(addr_o);

  exc_entry_seq u_dut (
    .clk_i, .rst_ni, .start_i, .kind_i, .emu_i, .pbr_i, .pc_i, .p_i, .sp_i, .rdata_i,
    .op_o, .addr_o, .wdata_o, .busy_o, .done_o, .new_pc_o, .new_pbr_o, .sp_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(int kind, bit emu);
    case (kind)
      0: return 16'hFFFC;
      1: return emu ? 16'hFFFA : 16'hFFEA;
      2: return emu ? 16'hFFFE : 16'hFFEE;
      3: return emu ? 16'hFFF8 : 16'hFFE8;
      default: return emu ? 16'hFFFE : 16'hFFE6;
    endcase
  endfunction

  task automatic run_seq(input int kind, input bit emu, input logic [7:0] pbr,
                         input logic [15:0] pc, input logic [7:0] p,
                         input logic [15:0] sp, input bit stray);
    logic [1:0]  e_op[12];
    logic [23:0] e_ad[12];
    logic [7:0]  e_wd[12];
    string       e_rq[12];
    int          n = 0;
    logic [15:0] s;
    logic [15:0] v;
    logic [7:0]  bytes[4];
    logic [1:0]  sop;
    sop = (kind == 0) ? 2'd3 : 2'd2;
    for (int i = 0; i < (kind == 4 ? 1 : 2); i++) begin
      e_op[n] = 2'd1; e_ad[n] = {pbr, pc}; e_wd[n] = 8'h00; e_rq[n] = "R3"; n++;
    end
    s = emu ? {8'h01, sp[7:0]} : sp;
    bytes[0] = pbr; bytes[1] = pc[15:8]; bytes[2] = pc[7:0]; bytes[3] = p;
    for (int i = (emu ? 1 : 0); i < 4; i++) begin
      e_op[n] = sop; e_ad[n] = {8'h00, s};
      e_wd[n] = (sop == 2'd2) ? bytes[i] : 8'h00;
      e_rq[n] = (kind == 0) ? "R7" : (emu ? "R5" : "R4"); n++;
      s = emu ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
    end
    v = vec_of(kind, emu);
    e_op[n] = 2'd3; e_ad[n] = {8'h00, v}; e_wd[n] = 8'h00; e_rq[n] = "R8"; n++;
    e_op[n] = 2'd3; e_ad[n] = {8'h00, v + 16'd1}; e_wd[n] = 8'h00; e_rq[n] = "R8"; n++;

    @(negedge clk_i);
    kind_i = kind[2:0]; emu_i = emu; pbr_i = pbr; pc_i = pc; p_i = p; sp_i = sp;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(op_o == e_op[i], e_rq[i], "op", 32'(op_o), 32'(e_op[i]));
      chk(addr_o == e_ad[i], (e_rq[i] == "R8" || i < 2) ? e_rq[i] : "R6", "addr",
          32'(addr_o), 32'(e_ad[i]));
      chk(wdata_o == e_wd[i], "R2", "wdata", 32'(wdata_o), 32'(e_wd[i]));
      if (stray && i == 2) begin
        start_i = 1'b1; kind_i = 3'd3; pc_i = ~pc; // R10 stray strobe
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(done_o === 1'b1, "R9", "done", 32'(done_o), 32'd1);
    chk(new_pc_o == {mem({8'h00, v + 16'd1}), mem({8'h00, v})}, "R9", "new_pc",
        32'(new_pc_o), 32'({mem({8'h00, v + 16'd1}), mem({8'h00, v})}));
    chk(new_pbr_o == 8'h00, "R9", "new_pbr", 32'(new_pbr_o), 32'd0);
    chk(sp_o == s, "R6", "sp_final", 32'(sp_o), 32'(s));
    chk(op_o == 2'd0, "R2", "op_done", 32'(op_o), 32'd0);
    @(negedge clk_i);
    chk(busy_o == 1'b0 && done_o == 1'b0, stray ? "R10" : "R9", "idle_after",
        32'({busy_o, done_o}), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] sps[4];
    logic [15:0] pcs[4];
    sps[0] = 16'h01FF; sps[1] = 16'h0101; sps[2] = 16'h0002; sps[3] = 16'h8000;
    pcs[0] = 16'h1234; pcs[1] = 16'hFFFF; pcs[2] = 16'h0000; pcs[3] = 16'hA55A;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && op_o == 0 && wdata_o == 0, "R1", "reset_state",
        32'({busy_o, done_o, op_o, wdata_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 0 && op_o == 0, "R1", "idle_after_reset", 32'({busy_o, op_o}), 32'd0);
    for (int k = 0; k < 5; k++)
      for (int e = 0; e < 2; e++)
        for (int t = 0; t < 4; t++)
          run_seq(k, e[0], 8'(8'h10 + 8'(t) * 8'h31), pcs[t], 8'(8'hC3 ^ 8'(k * 16 + t)),
                  sps[t], (t == 1));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule